// File: doc/BRIEF.md
# External Parallel Bus Controller

This block sits between a processor core and off-chip memories and peripherals. The core issues single accesses through a request port. Each request carries a space code, a direction, a 16-bit address and 16-bit write data. The controller then runs a strobed external cycle on a shared address bus and a shared bidirectional data bus. Three active-low selects tell the outside world whether program memory, data memory or I/O space is addressed. Wait cycles are added for as long as the external ready input stays low. A read returns its data to the core with a one-cycle done pulse.

The block follows FPGA practice and does not instantiate pad buffers. Every bus pin leaves the block as a value plus an output enable, and the pad ring above it builds the tri-states. The data bus enable is asserted only while write data is being driven. The control-pin enable drops during reset, during power-down and while the active-low float input is held low. The address enable drops only under float, so the address pins keep their last value through power-down.

Top module: `ebus_ctrl`

## Requirements
- R1: While `rst` is high, `ctl_oe` and `data_oe` are low. After reset, `strb_n` and `we_n` are 1, all `sel_n` bits are 1, `rw_o` is 1, `wr_o` is 0, `addr_o` is 0 and `req_ready` is 1.
- R2: Space code 0 selects program space (`sel_n[0]`), code 1 selects data space (`sel_n[1]`) and code 2 selects I/O space (`sel_n[2]`). Only the addressed select is low, and it stays low from the first setup cycle through the completion cycle. A request with code 3 starts no cycle.
- R3: In each strobe-active cycle, `ext_ready` is sampled at the clock edge. If it is low, the strobe-active cycle repeats. An access with N low samples therefore shows `strb_n` low for N+1 cycles.
- R4: An accepted access runs as follows: SETUP_CYCLES cycles with `strb_n` high, then the strobe-active cycles, then one completion cycle with `strb_n` high, and then the block is idle again.
- R5: `rw_o` is 0 from the first setup cycle through the completion cycle of a write, and 1 at all other times. `wr_o` is always the inverse of `rw_o`.
- R6: `we_n` is low exactly in the strobe-active cycles of a write. It is high for every read.
- R7: `data_oe` is high only in the strobe-active and completion cycles of a write. While it is high, `data_o` equals the write data of that request.
- R8: While `float_n` is low, `addr_oe`, `ctl_oe` and `data_oe` are all low.
- R9: A read captures `data_i` at the edge where ready is seen high. `rsp_done` is high for exactly one cycle, the cycle after the completion cycle, and at that point `rsp_rdata` holds the captured value.
- R10: `req_ready` is high only when the block is idle and not powered down. A `req_valid` seen while `req_ready` is low is ignored.
- R11: `pd_req` is sampled only in idle cycles in which no request is accepted. Power-down therefore never starts or ends inside an access. While powered down, `ctl_oe` and `data_oe` are low, and `addr_oe` stays high with `addr_o` unchanged.
- R12: `addr_o` takes the request address from the first setup cycle onwards and holds it until the next accepted request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core request strobe |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_space | input | 2 | 0 program, 1 data, 2 I/O, 3 none |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DW | Captured read data |
| pd_req | input | 1 | Power-down request |
| float_n | input | 1 | Active-low force-float |
| ext_ready | input | 1 | External ready |
| addr_o | output | AW | Address pin values |
| addr_oe | output | 1 | Address pin enable |
| data_i | input | DW | Data pins as seen from the pads |
| data_o | output | DW | Data pin drive values |
| data_oe | output | 1 | Data pin enable |
| ctl_oe | output | 1 | Enable for selects, strobe, direction and write enable |
| sel_n | output | 3 | Active-low space selects |
| strb_n | output | 1 | Active-low bus strobe |
| rw_o | output | 1 | Direction, high for read |
| wr_o | output | 1 | Inverted direction |
| we_n | output | 1 | Active-low write enable |

## Verification
The bench builds the controller with 16-bit address and data and with SETUP_CYCLES set to 2. A two-cycle setup makes the setup counter run through more than one value, so an off-by-one in its terminal count becomes visible on `strb_n`, `sel_n` and `rw_o`. The ready pattern is varied from zero to five low samples. The stimulus also covers these cases:
- power-down requested in the middle of a write;
- float held low for a whole access;
- requests with the unused space code;
- requests repeated while the block is busy.

// File: rtl/ebus_pkg.sv
package ebus_pkg;
  localparam int NSPACE = 3;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_ACTIVE = 2'd2,
    ST_DONE   = 2'd3
  } bus_state_e;

  localparam logic [1:0] SPACE_NONE = 2'd3;
endpackage

// File: rtl/ebus_seq.sv
module ebus_seq
  import ebus_pkg::*;
#(
  parameter int AW           = 16,
  parameter int DW           = 16,
  parameter int SETUP_CYCLES = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [1:0]    req_space,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          pd_req,
  input  logic          ext_ready,
  input  logic [DW-1:0] data_i,
  output bus_state_e    state_nxt,
  output logic          write_nxt,
  output logic [1:0]    space_nxt,
  output logic [AW-1:0] acc_addr,
  output logic [DW-1:0] acc_wdata,
  output logic          pd_q,
  output logic          req_ready,
  output logic          rsp_done,
  output logic [DW-1:0] rsp_rdata
);
  localparam int CW = (SETUP_CYCLES < 2) ? 1 : $clog2(SETUP_CYCLES);
  localparam logic [CW-1:0] SETUP_LAST = CW'(SETUP_CYCLES - 1);

  bus_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic          write_q;
  logic [1:0]    space_q;
  logic          accept;

  assign req_ready = (state_q == ST_IDLE) && !pd_q;
  assign accept    = req_ready && req_valid && (req_space != SPACE_NONE);
  assign write_nxt = accept ? req_write : write_q;
  assign space_nxt = accept ? req_space : space_q;

  always_comb begin
    state_nxt = state_q;
    case (state_q)
      ST_IDLE:   if (accept) state_nxt = ST_SETUP;
      ST_SETUP:  if (cnt_q == SETUP_LAST) state_nxt = ST_ACTIVE;
      ST_ACTIVE: if (ext_ready) state_nxt = ST_DONE;
      default:   state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      write_q   <= 1'b0;
      space_q   <= 2'd0;
      acc_addr  <= '0;
      acc_wdata <= '0;
      pd_q      <= 1'b0;
      rsp_done  <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      state_q  <= state_nxt;
      rsp_done <= (state_q == ST_DONE);
      if (state_q == ST_SETUP && state_nxt == ST_SETUP) cnt_q <= cnt_q + 1'b1;
      else cnt_q <= '0;
      if (accept) begin
        write_q   <= req_write;
        space_q   <= req_space;
        acc_addr  <= req_addr;
        acc_wdata <= req_wdata;
      end else if (state_q == ST_IDLE) begin
        pd_q <= pd_req;
      end
      if (state_q == ST_ACTIVE && ext_ready && !write_q) rsp_rdata <= data_i;
    end
  end

  // R3: a low ready keeps the strobe-active state
  p_wait_state_r3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ACTIVE && !ext_ready) |=> (state_q == ST_ACTIVE));
  // R11: power-down does not change inside an access
  p_pd_between_r11: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE) |=> $stable(pd_q));
  // R9: done is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);
endmodule

// File: rtl/ebus_sel_decode.sv
module ebus_sel_decode
  import ebus_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  bus_state_e        state_nxt,
  input  logic [1:0]        space_nxt,
  output logic [NSPACE-1:0] sel_n
);
  logic busy_nxt;
  assign busy_nxt = (state_nxt != ST_IDLE);

  for (genvar g = 0; g < NSPACE; g++) begin : g_sel
    always_ff @(posedge clk) begin
      if (rst) sel_n[g] <= 1'b1;
      else     sel_n[g] <= !(busy_nxt && (space_nxt == 2'(g)));
    end
  end

  // R2: at most one space selected at a time
  p_one_sel_r2: assert property (@(posedge clk) disable iff (rst)
    $countones(~sel_n) <= 1);
endmodule

// File: rtl/ebus_pins.sv
module ebus_pins
  import ebus_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  bus_state_e state_nxt,
  input  logic       write_nxt,
  output logic       strb_n,
  output logic       we_n,
  output logic       rw_o,
  output logic       wr_o,
  output logic       drive_q
);
  logic busy_nxt;
  assign busy_nxt = (state_nxt != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      strb_n  <= 1'b1;
      we_n    <= 1'b1;
      rw_o    <= 1'b1;
      wr_o    <= 1'b0;
      drive_q <= 1'b0;
    end else begin
      strb_n  <= !(state_nxt == ST_ACTIVE);
      we_n    <= !(state_nxt == ST_ACTIVE && write_nxt);
      rw_o    <= !(busy_nxt && write_nxt);
      wr_o    <= busy_nxt && write_nxt;
      drive_q <= ((state_nxt == ST_ACTIVE) || (state_nxt == ST_DONE)) && write_nxt;
    end
  end

  // R6: write enable only inside a strobed write
  p_we_in_strobe_r6: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> (!strb_n && !rw_o));
  // R5: direction outputs never agree
  p_dir_pair_r5: assert property (@(posedge clk) disable iff (rst)
    rw_o != wr_o);
endmodule

// File: rtl/ebus_ctrl.sv
module ebus_ctrl
  import ebus_pkg::*;
#(
  parameter int AW           = 16,
  parameter int DW           = 16,
  parameter int SETUP_CYCLES = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_space,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              rsp_done,
  output logic [DW-1:0]     rsp_rdata,
  input  logic              pd_req,
  input  logic              float_n,
  input  logic              ext_ready,
  output logic [AW-1:0]     addr_o,
  output logic              addr_oe,
  input  logic [DW-1:0]     data_i,
  output logic [DW-1:0]     data_o,
  output logic              data_oe,
  output logic              ctl_oe,
  output logic [NSPACE-1:0] sel_n,
  output logic              strb_n,
  output logic              rw_o,
  output logic              wr_o,
  output logic              we_n
);
  bus_state_e state_nxt;
  logic       write_nxt;
  logic [1:0] space_nxt;
  logic       pd_q;
  logic       drive_q;

  ebus_seq #(.AW(AW), .DW(DW), .SETUP_CYCLES(SETUP_CYCLES)) u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_space(req_space),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .pd_req(pd_req), .ext_ready(ext_ready), .data_i(data_i),
    .state_nxt(state_nxt), .write_nxt(write_nxt), .space_nxt(space_nxt),
    .acc_addr(addr_o), .acc_wdata(data_o), .pd_q(pd_q),
    .req_ready(req_ready), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata)
  );

  ebus_sel_decode u_sel (
    .clk(clk), .rst(rst), .state_nxt(state_nxt), .space_nxt(space_nxt),
    .sel_n(sel_n)
  );

  ebus_pins u_pins (
    .clk(clk), .rst(rst), .state_nxt(state_nxt), .write_nxt(write_nxt),
    .strb_n(strb_n), .we_n(we_n), .rw_o(rw_o), .wr_o(wr_o), .drive_q(drive_q)
  );

  assign ctl_oe  = !rst && !pd_q && float_n;
  assign data_oe = ctl_oe && drive_q;
  assign addr_oe = float_n;

  // R7: data is driven only in a write
  p_drive_write_r7: assert property (@(posedge clk) disable iff (rst)
    data_oe |-> (!rw_o && !sel_n[0] | !sel_n[1] | !sel_n[2]));
  // R12: address holds while the strobe is low
  p_addr_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !strb_n |-> $stable(addr_o));
  // R4: the strobe only falls inside a selected cycle
  p_strb_sel_r4: assert property (@(posedge clk) disable iff (rst)
    !strb_n |-> (sel_n != '1));
endmodule

// File: tb/ebus_ctrl_tb.sv
module ebus_ctrl_tb_top;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int SETUP = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst = 1'b1;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]    req_space = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          pd_req = 1'b0, float_n = 1'b1, ext_ready = 1'b1;
  logic [DW-1:0] data_i = '0;
  logic          req_ready, rsp_done, addr_oe, data_oe, ctl_oe;
  logic          strb_n, rw_o, wr_o, we_n;
  logic [DW-1:0] rsp_rdata, data_o;
  logic [AW-1:0] addr_o;
  logic [2:0]    sel_n;

  ebus_ctrl #(.AW(AW), .DW(DW), .SETUP_CYCLES(SETUP)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_space(req_space), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .pd_req(pd_req), .float_n(float_n), .ext_ready(ext_ready),
    .addr_o(addr_o), .addr_oe(addr_oe), .data_i(data_i), .data_o(data_o),
    .data_oe(data_oe), .ctl_oe(ctl_oe), .sel_n(sel_n), .strb_n(strb_n),
    .rw_o(rw_o), .wr_o(wr_o), .we_n(we_n)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0, waits_left = 0;
  bit primed = 0;

  task automatic check(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  // behavioural reference: 0 idle, 1 setup, 2 strobe, 3 completion
  int m_st = 0, m_cnt = 0, m_space = 0, m_addr = 0, m_wdata = 0, m_rdata = 0;
  bit m_pd = 0, m_wr = 0, m_done = 0;

  always @(posedge clk) begin
    bit dn;
    dn = 0;
    if (rst) begin
      m_st = 0; m_cnt = 0; m_pd = 0; m_wr = 0; m_space = 0;
      m_addr = 0; m_wdata = 0; m_rdata = 0;
    end else begin
      case (m_st)
        0: if (!m_pd && req_valid && req_space != 2'd3) begin
             m_st = 1; m_cnt = 0; m_addr = int'(req_addr); m_wdata = int'(req_wdata);
             m_wr = req_write; m_space = int'(req_space);
           end else m_pd = pd_req;
        1: if (m_cnt == SETUP - 1) m_st = 2; else m_cnt++;
        2: if (ext_ready) begin
             if (!m_wr) m_rdata = int'(data_i);
             m_st = 3;
           end
        default: begin m_st = 0; dn = 1; end
      endcase
    end
    m_done = dn;
    primed = 1;
    cyc++;
    if (cyc > 50000) begin
      n_bad++;
      $display("FAIL R4 watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (primed) begin
      bit busy, cen;
      busy = (m_st != 0);
      cen  = !rst && !m_pd && float_n;
      check("R2", "sel_n", int'(sel_n), busy ? (~(1 << m_space) & 7) : 7);
      check("R4", "strb_n", int'(strb_n), int'(m_st != 2));
      check("R5", "rw_o", int'(rw_o), int'(!(busy && m_wr)));
      check("R5", "wr_o", int'(wr_o), int'(busy && m_wr));
      check("R6", "we_n", int'(we_n), int'(!(m_st == 2 && m_wr)));
      check("R7", "data_oe", int'(data_oe), int'(cen && (m_st >= 2) && m_wr));
      if (data_oe) check("R7", "data_o", int'(data_o), m_wdata);
      check("R8", "ctl_oe", int'(ctl_oe), int'(cen));
      check("R8", "addr_oe", int'(addr_oe), int'(float_n));
      check("R9", "rsp_done", int'(rsp_done), int'(m_done));
      check("R9", "rsp_rdata", int'(rsp_rdata), m_rdata);
      check("R10", "req_ready", int'(req_ready), int'(m_st == 0 && !m_pd));
      check("R12", "addr_o", int'(addr_o), m_addr);
    end
    ext_ready = 1'b1;
    if (!strb_n && waits_left > 0) begin
      ext_ready = 1'b0;
      waits_left--;
    end
  end

  task automatic access(int sp, bit wr, int addr, int wd, int waits, int rd);
    int n_lo = 0;
    bit seen = 0;
    @(negedge clk);
    waits_left = waits; data_i = DW'(rd);
    req_valid = 1'b1; req_space = 2'(sp); req_write = wr;
    req_addr = AW'(addr); req_wdata = DW'(wd);
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 200; i++) begin
      if (!strb_n) n_lo++;
      if (rsp_done) begin seen = 1; break; end
      @(negedge clk);
    end
    check("R4", "done seen", int'(seen), 1);
    check("R3", "strobe-low cycles", n_lo, waits + 1);
    if (!wr) check("R9", "read data", int'(rsp_rdata), rd);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "ctl_oe in reset", int'(ctl_oe), 0);
    check("R1", "data_oe in reset", int'(data_oe), 0);
    check("R1", "strb_n", int'(strb_n), 1);
    check("R1", "sel_n", int'(sel_n), 7);
    check("R1", "rw_o", int'(rw_o), 1);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "ctl_oe after reset", int'(ctl_oe), 1);
    check("R1", "req_ready", int'(req_ready), 1);

    access(0, 0, 'h1234, 0, 0, 'hBEEF);
    access(1, 1, 'hFFFF, 'hA55A, 2, 0);
    access(2, 0, 'h0001, 0, 3, 'h0F0F);
    access(1, 0, 'h8000, 0, 5, 'h7777);
    access(2, 1, 'h00F0, 'h1357, 0, 0);
    access(0, 0, 'h4000, 0, 1, 'h2468);

    // R2: space code 3 starts nothing
    @(negedge clk);
    req_valid = 1'b1; req_space = 2'd3; req_addr = 16'h9999;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (4) @(negedge clk);
    check("R2", "no cycle for code 3 strb_n", int'(strb_n), 1);
    check("R2", "no cycle for code 3 sel_n", int'(sel_n), 7);

    // R10: request held while busy is taken only once
    begin
      int n_lo = 0;
      @(negedge clk);
      waits_left = 1; req_valid = 1'b1; req_space = 2'd1; req_write = 1'b1;
      req_addr = 16'h0A0A; req_wdata = 16'hC3C3;
      for (int i = 0; i < 4; i++) begin @(negedge clk); if (!strb_n) n_lo++; end
      req_valid = 1'b0;
      for (int i = 0; i < 12; i++) begin @(negedge clk); if (!strb_n) n_lo++; end
      check("R10", "strobe cycles for held request", n_lo, 2);
    end

    // R11: power-down in idle
    @(negedge clk); pd_req = 1'b1;
    repeat (2) @(negedge clk);
    check("R11", "ctl_oe powered down", int'(ctl_oe), 0);
    check("R11", "addr_oe powered down", int'(addr_oe), 1);
    req_valid = 1'b1; req_space = 2'd0; req_write = 1'b0; req_addr = 16'h5555;
    @(negedge clk); req_valid = 1'b0;
    repeat (4) @(negedge clk);
    check("R11", "address held in power-down", int'(addr_o), 'h0A0A);
    check("R10", "req_ready powered down", int'(req_ready), 0);
    pd_req = 1'b0;
    repeat (2) @(negedge clk);
    check("R11", "ctl_oe after wake", int'(ctl_oe), 1);

    // R11: power-down raised inside an access waits for idle
    fork
      access(1, 1, 'h0C0C, 'h5A5A, 3, 0);
      begin
        repeat (3) @(negedge clk);
        pd_req = 1'b1;
        check("R11", "ctl_oe mid access", int'(ctl_oe), 1);
      end
    join
    repeat (2) @(negedge clk);
    check("R11", "ctl_oe after access", int'(ctl_oe), 0);
    pd_req = 1'b0;
    repeat (2) @(negedge clk);

    // R8: whole write under float
    float_n = 1'b0;
    access(2, 1, 'h3030, 'h0FF0, 2, 0);
    check("R8", "addr_oe under float", int'(addr_oe), 0);
    check("R8", "data_oe under float", int'(data_oe), 0);
    float_n = 1'b1;

    access(0, 1, 'h7FFF, 'hFFFF, 0, 0);
    access(1, 0, 'h0000, 0, 4, 'h8001);
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule